// File: doc/BRIEF.md
# Scalar Special-Group Integer Execute Stage

This block is the integer execute stage for the register-to-register ("special") instruction group of a 32-bit scalar core that sits inside a vector coprocessor. It receives the fields already pulled out of the instruction: the destination index, the immediate shift amount and the 6-bit function code. It also receives the two source operand values and the address of the instruction. From these it produces a destination register write, a jump request with its target, and a break indication.

All results are registered, so they appear one clock after the instruction is issued. The function codes that a full 32-bit RISC core would use for system calls, barriers, HI/LO moves, multiply and divide, 64-bit arithmetic and trap compares are not implemented here. The same is true of every other unassigned code. None of these codes trap, and none is a no-op. Each one writes the destination with the first source operand shifted logically right by the operand's own low five bits. There is no other side effect.

The register file, instruction fetch, delay-slot sequencing and the other opcode groups live outside this block.

Top module: `spx_exec`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs have `wr_en_o`, `jump_o` and `brk_o` low.
- R2: Results appear exactly one clock after `issue_i` is sampled high. A cycle with `issue_i` low yields no write, no jump and no break on the next cycle.
- R3: Function 0x00 shifts `rt_val_i` left by `sa_i`. Function 0x02 shifts it logically right by `sa_i`, and 0x03 shifts it arithmetically right by `sa_i`. The result goes to `rd_i`.
- R4: Functions 0x04 (left), 0x06 (logical right) and 0x07 (arithmetic right) shift `rt_val_i` by `rs_val_i[4:0]`.
- R5: Functions 0x20 and 0x21 write the 32-bit wrapping sum `rs+rt`. Functions 0x22 and 0x23 write the wrapping difference `rs-rt`. There is never an exception.
- R6: Functions 0x24, 0x25, 0x26 and 0x27 write AND, OR, XOR and NOR of `rs_val_i` and `rt_val_i`.
- R7: Function 0x2a writes 1 if `rs<rt` as signed numbers and 0 otherwise. Function 0x2b does the same compare as unsigned numbers.
- R8: Function 0x08 raises `jump_o` with `jump_tgt_o = rs_val_i[11:0]` and performs no write.
- R9: Function 0x09 raises `jump_o` to `rs_val_i[11:0]` and writes `rd_i` with `(pc_i + 8) mod 4096`, zero-extended.
- R10: Function 0x0d raises `brk_o` for one cycle with no write and no jump. `jump_o` and `brk_o` are never high together.
- R11: Every function code not named in R3 to R10 writes `rd_i` with `rs_val_i >> rs_val_i[4:0]` (logical shift). `rt_val_i` is ignored, and there is no jump or break. This covers 0x01, 0x05, 0x0a-0x0c, 0x0e-0x1f, 0x28, 0x29 and 0x2c-0x3f.
- R12: A write whose destination index is 0 is suppressed, so `wr_en_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction presented this cycle |
| func_i | input | 6 | Function code |
| rd_i | input | 5 | Destination register index |
| sa_i | input | 5 | Immediate shift amount |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| pc_i | input | 12 | Address of the instruction |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 32 | Destination write data |
| jump_o | output | 1 | Jump request |
| jump_tgt_o | output | 12 | Jump target address |
| brk_o | output | 1 | Break indication |

## Verification
The properties assume that every input is a defined value at each rising edge while `issue_i` is high. They also assume that `pc_i` already lies in the 12-bit instruction space, since the link check compares against a 12-bit sum. The bench drives every input at the falling edge and holds it through the next rising edge. Inputs stay at known values even in idle cycles, and no instruction is issued while reset is asserted. The only exception is one deliberate mid-run reset, which checks that a pending write is dropped.

// File: rtl/spx_pkg.sv
package spx_pkg;

    localparam int XLEN_DEF    = 32;
    localparam int IMEM_AW_DEF = 12;
    localparam int RIDX_W      = 5;
    localparam int FN_W        = 6;
    localparam int LINK_OFS    = 8;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
    localparam logic [FN_W-1:0] FN_JR   = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR = 6'h09;
    localparam logic [FN_W-1:0] FN_BRK  = 6'h0d;
    localparam logic [FN_W-1:0] FN_ADDA = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDB = 6'h21;
    localparam logic [FN_W-1:0] FN_SUBA = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBB = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2a;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2b;

    // Internal operation selector carried from decode to the units.
    typedef enum logic [4:0] {
        OP_SLL, OP_SRL, OP_SRA,
        OP_SLLV, OP_SRLV, OP_SRAV,
        OP_ADD, OP_SUB,
        OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_SLT, OP_SLTU,
        OP_JR, OP_JALR, OP_BRK,
        OP_FILL          // every unassigned code: rs >> rs[4:0]
    } op_e;

    typedef struct packed {
        op_e  op;
        logic wr;
        logic jmp;
        logic brk;
    } ctrl_t;

    function automatic logic op_is_shift(input op_e op);
        return (op == OP_SLL)  || (op == OP_SRL)  || (op == OP_SRA)  ||
               (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV) ||
               (op == OP_FILL);
    endfunction

    function automatic logic op_is_arith(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR) || (op == OP_NOR) ||
               (op == OP_SLT) || (op == OP_SLTU);
    endfunction

endpackage

// File: rtl/spx_decode.sv
module spx_decode
    import spx_pkg::*;
(
    input  logic [FN_W-1:0] func_i,
    output ctrl_t           ctrl_o
);

    always_comb begin
        ctrl_o = '{op: OP_FILL, wr: 1'b1, jmp: 1'b0, brk: 1'b0};
        case (func_i)
            FN_SLL:  ctrl_o.op = OP_SLL;
            FN_SRL:  ctrl_o.op = OP_SRL;
            FN_SRA:  ctrl_o.op = OP_SRA;
            FN_SLLV: ctrl_o.op = OP_SLLV;
            FN_SRLV: ctrl_o.op = OP_SRLV;
            FN_SRAV: ctrl_o.op = OP_SRAV;
            FN_JR: begin
                ctrl_o.op  = OP_JR;
                ctrl_o.wr  = 1'b0;
                ctrl_o.jmp = 1'b1;
            end
            FN_JALR: begin
                ctrl_o.op  = OP_JALR;
                ctrl_o.jmp = 1'b1;
            end
            FN_BRK: begin
                ctrl_o.op  = OP_BRK;
                ctrl_o.wr  = 1'b0;
                ctrl_o.brk = 1'b1;
            end
            FN_ADDA, FN_ADDB: ctrl_o.op = OP_ADD;
            FN_SUBA, FN_SUBB: ctrl_o.op = OP_SUB;
            FN_AND:  ctrl_o.op = OP_AND;
            FN_OR:   ctrl_o.op = OP_OR;
            FN_XOR:  ctrl_o.op = OP_XOR;
            FN_NOR:  ctrl_o.op = OP_NOR;
            FN_SLT:  ctrl_o.op = OP_SLT;
            FN_SLTU: ctrl_o.op = OP_SLTU;
            default: ctrl_o.op = OP_FILL;
        endcase
    end

endmodule

// File: rtl/spx_shift.sv
module spx_shift
    import spx_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    localparam int SHW = $clog2(XLEN)
) (
    input  op_e             op_i,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rt_i,
    input  logic [SHW-1:0]  sa_i,
    output logic [XLEN-1:0] res_o
);

    logic [XLEN-1:0] src;
    logic [SHW-1:0]  amt;
    logic            left;
    logic            arith;

    always_comb begin
        src   = rt_i;
        amt   = sa_i;
        left  = 1'b0;
        arith = 1'b0;
        case (op_i)
            OP_SLL:  left = 1'b1;
            OP_SRL:  ;
            OP_SRA:  arith = 1'b1;
            OP_SLLV: begin amt = rs_i[SHW-1:0]; left = 1'b1; end
            OP_SRLV: amt = rs_i[SHW-1:0];
            OP_SRAV: begin amt = rs_i[SHW-1:0]; arith = 1'b1; end
            default: begin src = rs_i; amt = rs_i[SHW-1:0]; end
        endcase
    end

    logic            fill;
    logic [XLEN-1:0] src_rev;
    logic [XLEN-1:0] pre;
    logic [XLEN-1:0] stg [SHW+1];
    logic [XLEN-1:0] out_rev;

    assign fill = arith & src[XLEN-1];

    // Left shifts reuse the right-shift network on a bit-reversed word.
    for (genvar b = 0; b < XLEN; b++) begin : g_rev_in
        assign src_rev[b] = src[XLEN-1-b];
    end

    assign pre    = left ? src_rev : src;
    assign stg[0] = pre;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
    end

    for (genvar b = 0; b < XLEN; b++) begin : g_rev_out
        assign out_rev[b] = stg[SHW][XLEN-1-b];
    end

    assign res_o = left ? out_rev : stg[SHW];

endmodule

// File: rtl/spx_alu.sv
module spx_alu
    import spx_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  op_e             op_i,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rt_i,
    output logic [XLEN-1:0] res_o
);

    logic            sub;
    logic [XLEN-1:0] b_op;
    logic [XLEN:0]   sum;
    logic            lt_s;
    logic            lt_u;

    // One adder serves add, subtract and both compares.
    assign sub  = (op_i != OP_ADD);
    assign b_op = sub ? ~rt_i : rt_i;
    assign sum  = {1'b0, rs_i} + {1'b0, b_op} + {{XLEN{1'b0}}, sub};

    assign lt_u = ~sum[XLEN];
    assign lt_s = (rs_i[XLEN-1] ^ rt_i[XLEN-1]) ? rs_i[XLEN-1] : sum[XLEN-1];

    always_comb begin
        case (op_i)
            OP_ADD, OP_SUB: res_o = sum[XLEN-1:0];
            OP_AND:  res_o = rs_i & rt_i;
            OP_OR:   res_o = rs_i | rt_i;
            OP_XOR:  res_o = rs_i ^ rt_i;
            OP_NOR:  res_o = ~(rs_i | rt_i);
            OP_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: res_o = {{(XLEN-1){1'b0}}, lt_u};
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/spx_exec.sv
module spx_exec
    import spx_pkg::*;
#(
    parameter int XLEN    = XLEN_DEF,
    parameter int IMEM_AW = IMEM_AW_DEF,
    localparam int SHW    = $clog2(XLEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic [FN_W-1:0]    func_i,
    input  logic [RIDX_W-1:0]  rd_i,
    input  logic [SHW-1:0]     sa_i,
    input  logic [XLEN-1:0]    rs_val_i,
    input  logic [XLEN-1:0]    rt_val_i,
    input  logic [IMEM_AW-1:0] pc_i,
    output logic               wr_en_o,
    output logic [RIDX_W-1:0]  wr_idx_o,
    output logic [XLEN-1:0]    wr_data_o,
    output logic               jump_o,
    output logic [IMEM_AW-1:0] jump_tgt_o,
    output logic               brk_o
);

    ctrl_t              ctrl;
    logic [XLEN-1:0]    shift_res;
    logic [XLEN-1:0]    alu_res;
    logic [IMEM_AW-1:0] link;
    logic [XLEN-1:0]    result;

    spx_decode i_dec (
        .func_i (func_i),
        .ctrl_o (ctrl)
    );

    spx_shift #(.XLEN(XLEN)) i_shift (
        .op_i  (ctrl.op),
        .rs_i  (rs_val_i),
        .rt_i  (rt_val_i),
        .sa_i  (sa_i),
        .res_o (shift_res)
    );

    spx_alu #(.XLEN(XLEN)) i_alu (
        .op_i  (ctrl.op),
        .rs_i  (rs_val_i),
        .rt_i  (rt_val_i),
        .res_o (alu_res)
    );

    // Link address wraps inside the instruction memory range.
    assign link = pc_i + IMEM_AW'(LINK_OFS);

    always_comb begin
        if (op_is_shift(ctrl.op))
            result = shift_res;
        else if (op_is_arith(ctrl.op))
            result = alu_res;
        else if (ctrl.op == OP_JALR)
            result = {{(XLEN-IMEM_AW){1'b0}}, link};
        else
            result = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o    <= 1'b0;
            wr_idx_o   <= '0;
            wr_data_o  <= '0;
            jump_o     <= 1'b0;
            jump_tgt_o <= '0;
            brk_o      <= 1'b0;
        end else begin
            wr_en_o    <= issue_i & ctrl.wr & (rd_i != '0);
            wr_idx_o   <= rd_i;
            wr_data_o  <= result;
            jump_o     <= issue_i & ctrl.jmp;
            jump_tgt_o <= rs_val_i[IMEM_AW-1:0];
            brk_o      <= issue_i & ctrl.brk;
        end
    end

endmodule

// File: rtl/spx_exec_chk.sv
module spx_exec_chk #(
    parameter int XLEN    = 32,
    parameter int IMEM_AW = 12,
    localparam int SHW    = $clog2(XLEN)
) (
    input logic               clk,
    input logic               rst,
    input logic               issue_i,
    input logic [5:0]         func_i,
    input logic [4:0]         rd_i,
    input logic [XLEN-1:0]    rs_val_i,
    input logic [IMEM_AW-1:0] pc_i,
    input logic               wr_en_o,
    input logic [4:0]         wr_idx_o,
    input logic [XLEN-1:0]    wr_data_o,
    input logic               jump_o,
    input logic [IMEM_AW-1:0] jump_tgt_o,
    input logic               brk_o
);

    logic named;
    always_comb begin
        named = (func_i inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07,
                                6'h08, 6'h09, 6'h0d, 6'h2a, 6'h2b})
              || (func_i[5:3] == 3'b100);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_en_o && !jump_o && !brk_o)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> (!wr_en_o && !jump_o && !brk_o)); // R2

    AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_idx_o != 5'd0)); // R12

    AST_JR_TARGET: assert property (@(posedge clk) disable iff (rst)
        (issue_i && func_i == 6'h08) |=>
            (jump_o && !wr_en_o && jump_tgt_o == $past(rs_val_i[IMEM_AW-1:0]))); // R8

    AST_JALR_LINK: assert property (@(posedge clk) disable iff (rst)
        (issue_i && func_i == 6'h09 && rd_i != 5'd0) |=>
            (jump_o && wr_en_o &&
             wr_data_o == {{(XLEN-IMEM_AW){1'b0}}, $past(pc_i) + IMEM_AW'(8)})); // R9

    AST_BRK_ALONE: assert property (@(posedge clk) disable iff (rst)
        (issue_i && func_i == 6'h0d) |=> (brk_o && !wr_en_o && !jump_o)); // R10

    AST_JMP_BRK_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({jump_o, brk_o})); // R10

    AST_FILL_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !named && rd_i != 5'd0) |=>
            (wr_en_o && !jump_o && !brk_o &&
             wr_data_o == ($past(rs_val_i) >> $past(rs_val_i[SHW-1:0])))); // R11

endmodule

bind spx_exec spx_exec_chk #(.XLEN(XLEN), .IMEM_AW(IMEM_AW)) i_spx_exec_chk (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue_i),
    .func_i     (func_i),
    .rd_i       (rd_i),
    .rs_val_i   (rs_val_i),
    .pc_i       (pc_i),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o),
    .jump_o     (jump_o),
    .jump_tgt_o (jump_tgt_o),
    .brk_o      (brk_o)
);

// File: tb/test_spx_exec.sv
module test_spx_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_i = 1'b0;
    logic [5:0]  func_i = '0;
    logic [4:0]  rd_i = '0;
    logic [4:0]  sa_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [11:0] pc_i = '0;
    logic        wr_en_o;
    logic [4:0]  wr_idx_o;
    logic [31:0] wr_data_o;
    logic        jump_o;
    logic [11:0] jump_tgt_o;
    logic        brk_o;

    int n_total = 0;
    int n_bad   = 0;

    always #5 clk = ~clk;

    spx_exec i_spx_exec (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (issue_i),
        .func_i     (func_i),
        .rd_i       (rd_i),
        .sa_i       (sa_i),
        .rs_val_i   (rs_val_i),
        .rt_val_i   (rt_val_i),
        .pc_i       (pc_i),
        .wr_en_o    (wr_en_o),
        .wr_idx_o   (wr_idx_o),
        .wr_data_o  (wr_data_o),
        .jump_o     (jump_o),
        .jump_tgt_o (jump_tgt_o),
        .brk_o      (brk_o)
    );

    typedef struct packed {
        logic [5:0]  fn;
        logic [4:0]  sa;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 5'd4, 32'h0000_0000, 32'h0000_00F1, 32'h0000_0F10, 4'd3},  // R3 SLL
        '{6'h02, 5'd4, 32'h0000_0000, 32'h8000_0010, 32'h0800_0001, 4'd3},  // R3 SRL
        '{6'h03, 5'd4, 32'h0000_0000, 32'h8000_0010, 32'hF800_0001, 4'd3},  // R3 SRA
        '{6'h04, 5'd9, 32'h0000_0023, 32'h0000_0001, 32'h0000_0008, 4'd4},  // R4 SLLV
        '{6'h06, 5'd9, 32'h0000_0021, 32'h8000_0000, 32'h4000_0000, 4'd4},  // R4 SRLV
        '{6'h07, 5'd0, 32'h0000_001F, 32'h8000_0000, 32'hFFFF_FFFF, 4'd4},  // R4 SRAV
        '{6'h20, 5'd0, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 4'd5},  // R5 add wraps
        '{6'h21, 5'd0, 32'h0000_1234, 32'h0000_1111, 32'h0000_2345, 4'd5},  // R5
        '{6'h22, 5'd0, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 4'd5},  // R5 sub wraps
        '{6'h23, 5'd0, 32'h0000_0100, 32'h0000_0001, 32'h0000_00FF, 4'd5},  // R5
        '{6'h24, 5'd0, 32'hF0F0_FF00, 32'hFF00_0FF0, 32'hF000_0F00, 4'd6},  // R6 AND
        '{6'h25, 5'd0, 32'hF0F0_FF00, 32'hFF00_0FF0, 32'hFFF0_FFF0, 4'd6},  // R6 OR
        '{6'h26, 5'd0, 32'hF0F0_FF00, 32'hFF00_0FF0, 32'h0FF0_F0F0, 4'd6},  // R6 XOR
        '{6'h27, 5'd0, 32'hF0F0_FF00, 32'hFF00_0FF0, 32'h000F_000F, 4'd6},  // R6 NOR
        '{6'h2a, 5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 4'd7},  // R7 signed
        '{6'h2b, 5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'd7},  // R7 unsigned
        '{6'h01, 5'd7, 32'h8000_0004, 32'hAAAA_AAAA, 32'h0800_0000, 4'd11}, // R11
        '{6'h18, 5'd7, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0000_0001, 4'd11}, // R11
        '{6'h3f, 5'd7, 32'h0000_0100, 32'hAAAA_AAAA, 32'h0000_0100, 4'd11}, // R11
        '{6'h0c, 5'd7, 32'h1234_5688, 32'h0000_DEAD, 32'h0012_3456, 4'd11}, // R11
        '{6'h2c, 5'd7, 32'h0000_0042, 32'hAAAA_AAAA, 32'h0000_0010, 4'd11}  // R11
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one instruction for one cycle; outputs are sampled afterwards
    // at the falling edge that follows the capturing rising edge.
    task automatic run_op(input logic [5:0] fn, input logic [4:0] rd,
                          input logic [4:0] sa, input logic [31:0] rs,
                          input logic [31:0] rt, input logic [11:0] pc);
        @(negedge clk);
        issue_i  = 1'b1;
        func_i   = fn;
        rd_i     = rd;
        sa_i     = sa;
        rs_val_i = rs;
        rt_val_i = rt;
        pc_i     = pc;
        @(negedge clk);
        issue_i  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!wr_en_o && !jump_o && !brk_o, "R1 reset outputs",
              {29'd0, wr_en_o, jump_o, brk_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k].fn, 5'd5, VECS[k].sa, VECS[k].rs, VECS[k].rt, 12'h100);
            check(wr_en_o && wr_idx_o == 5'd5 && wr_data_o == VECS[k].exp,
                  $sformatf("R%0d table row %0d", VECS[k].req, k),
                  wr_data_o, VECS[k].exp);
            check(!jump_o && !brk_o, $sformatf("R%0d no side effect row %0d", VECS[k].req, k),
                  {30'd0, jump_o, brk_o}, 32'd0);
        end

        // R2: idle cycle after an issue produces nothing
        @(negedge clk);
        check(!wr_en_o && !jump_o && !brk_o, "R2 idle cycle",
              {29'd0, wr_en_o, jump_o, brk_o}, 32'd0);

        // R2: latency is exactly one clock
        @(negedge clk);
        issue_i = 1'b1; func_i = 6'h21; rd_i = 5'd3;
        rs_val_i = 32'd10; rt_val_i = 32'd20;
        check(!wr_en_o, "R2 not early", {31'd0, wr_en_o}, 32'd0);
        @(negedge clk);
        issue_i = 1'b0;
        check(wr_en_o && wr_data_o == 32'd30, "R2 one-cycle result", wr_data_o, 32'd30);

        // R8: JR
        run_op(6'h08, 5'd4, 5'd0, 32'h0000_1ABC, 32'h0, 12'h200);
        check(jump_o && jump_tgt_o == 12'hABC, "R8 jump target",
              {20'd0, jump_tgt_o}, 32'h0000_0ABC);
        check(!wr_en_o && !brk_o, "R8 no write", {30'd0, wr_en_o, brk_o}, 32'd0);

        // R9: JALR with link wrap
        run_op(6'h09, 5'd31, 5'd0, 32'h0000_0040, 32'h0, 12'hFFC);
        check(jump_o && jump_tgt_o == 12'h040, "R9 jump target",
              {20'd0, jump_tgt_o}, 32'h0000_0040);
        check(wr_en_o && wr_idx_o == 5'd31 && wr_data_o == 32'h0000_0004,
              "R9 link wraps", wr_data_o, 32'h0000_0004);
        run_op(6'h09, 5'd2, 5'd0, 32'h0000_0000, 32'h0, 12'h123);
        check(wr_en_o && wr_data_o == 32'h0000_012B, "R9 link", wr_data_o, 32'h0000_012B);

        // R10: BREAK
        run_op(6'h0d, 5'd6, 5'd0, 32'h1, 32'h2, 12'h0);
        check(brk_o && !jump_o && !wr_en_o, "R10 break alone",
              {29'd0, brk_o, jump_o, wr_en_o}, 32'h4);
        @(negedge clk);
        check(!brk_o, "R10 one-cycle pulse", {31'd0, brk_o}, 32'd0);

        // R12: destination 0 suppressed, for a normal op and an unassigned op
        run_op(6'h21, 5'd0, 5'd0, 32'h5, 32'h6, 12'h0);
        check(!wr_en_o, "R12 add to r0", {31'd0, wr_en_o}, 32'd0);
        run_op(6'h1a, 5'd0, 5'd0, 32'hFFFF_FFFF, 32'h6, 12'h0);
        check(!wr_en_o, "R12 unassigned to r0", {31'd0, wr_en_o}, 32'd0);
        run_op(6'h09, 5'd0, 5'd0, 32'h0000_0010, 32'h0, 12'h0);
        check(jump_o && !wr_en_o, "R12 JALR to r0 still jumps",
              {30'd0, jump_o, wr_en_o}, 32'h2);

        // R11: rt has no effect on the unassigned class
        run_op(6'h3a, 5'd9, 5'd3, 32'h0000_0F03, 32'h0000_0000, 12'h0);
        check(wr_en_o && wr_data_o == 32'h0000_01E0, "R11 rt zero", wr_data_o, 32'h0000_01E0);
        run_op(6'h3a, 5'd9, 5'd3, 32'h0000_0F03, 32'hFFFF_FFFF, 12'h0);
        check(wr_en_o && wr_data_o == 32'h0000_01E0, "R11 rt ones", wr_data_o, 32'h0000_01E0);

        // R1: reset while an instruction is presented drops it
        @(negedge clk);
        rst = 1'b1; issue_i = 1'b1; func_i = 6'h25; rd_i = 5'd8;
        rs_val_i = 32'h1; rt_val_i = 32'h2;
        @(negedge clk);
        check(!wr_en_o && !jump_o && !brk_o, "R1 mid-run reset",
              {29'd0, wr_en_o, jump_o, brk_o}, 32'd0);
        issue_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule